// File: doc/BRIEF.md
# Double-pumped warp issue sequencer

This block executes 32-element warp instructions on a group of 16 multiply-add lanes. The lanes run on the fast ALU clock, and instructions arrive at half that rate. Each accepted instruction is split in two. On the first fast cycle after acceptance the sequencer selects the warp's context for the lower half, elements 0 to 15. On the next cycle it selects the upper half, elements 16 to 31. Each lane computes `a*b + c` on 16-bit operands, and the result is registered one cycle after the read. Seen from the issuing side, the instruction behaves as one 32-wide operation that produces a single completion.

The whole block runs on the fast clock. The slow issue clock is represented by `issueEdge`, a strobe that marks the fast cycle ending on a slow-clock edge. The issue handshake is sampled only in those cycles. The register file sits outside the block. It returns the 16 lanes of operands in the same cycle that `rfWarp` and `rfHalf` select them. Up to 48 warps are resident. Any warp id of 48 or above is refused and raises an error pulse.

Top module: `warp_dual_pump_seq`

## Requirements
- R1: After reset, `instReady` is 1 and `rfRead`, `resValid`, `doneValid` and `instErr` are 0.
- R2: An instruction is taken only at a rising edge where `issueEdge`, `instValid` and `instReady` are all 1. While `issueEdge` is 0, the values on `instValid` and `instWarp` have no effect on any output.
- R3: In the fast cycle after a valid instruction is taken, `rfRead` is 1, `rfHalf` is 0 and `rfWarp` holds the warp id. In the cycle after that, `rfRead` is 1, `rfHalf` is 1 and `rfWarp` is unchanged. `rfHalf` = h selects elements h*16 to h*16+15, with lane i carrying element h*16+i.
- R4: One cycle after each context read, `resValid` is 1 and `resHalf` and `resWarp` repeat the read's half and warp. Lane i of `resData` (bits 16*i+15 down to 16*i) holds the low 16 bits of a*b+c, where a, b and c are lane i of `rfA`, `rfB` and `rfC`.
- R5: `doneValid` pulses for exactly one cycle per taken valid instruction, in the same cycle as the upper-half result, with `doneWarp` equal to the warp id.
- R6: `instReady` is 0 in the lower-half read cycle and 1 in every other cycle. This allows a new instruction to be taken at the issue edge that ends the upper-half read.
- R7: An instruction whose warp id is 48 or above is consumed without any context read or result. `instErr` is 1 for the one cycle that follows its acceptance edge.
- R8: Warp ids 0 and 47 are both accepted, and the same warp may be issued in consecutive issue slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aluClk | input | 1 | Fast ALU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueEdge | input | 1 | High in the fast cycle that ends on a slow issue-clock edge |
| instValid | input | 1 | Warp instruction offered |
| instWarp | input | 6 | Warp id of the offered instruction |
| instReady | output | 1 | Sequencer can take an instruction |
| instErr | output | 1 | One-cycle pulse: out-of-range warp id refused |
| rfRead | output | 1 | Context read strobe |
| rfWarp | output | 6 | Warp context being read |
| rfHalf | output | 1 | Half being read (0 lower, 1 upper) |
| rfA | input | 256 | Multiplicand, 16 lanes x 16 bits |
| rfB | input | 256 | Multiplier, 16 lanes x 16 bits |
| rfC | input | 256 | Addend, 16 lanes x 16 bits |
| resValid | output | 1 | Lane results valid |
| resHalf | output | 1 | Half of the results |
| resWarp | output | 6 | Warp of the results |
| resData | output | 256 | 16 lane results |
| doneValid | output | 1 | Warp instruction complete |
| doneWarp | output | 6 | Warp id of the completed instruction |

## Verification
Counting from the rising edge that takes an instruction, the lower-half read is visible one fast cycle later, the lower-half result two cycles later, and the upper-half result together with the completion three cycles later. An error pulse appears one cycle after the edge that refuses the instruction. The bench works in issue slots of two fast cycles and samples every output on falling edges. In each slot it checks the previous instruction's lower result at the first falling edge, then its upper result, completion and the current instruction's read at the second. Every check therefore lands in the cycle where its registered value is first held.

// File: rtl/warp_seq_pkg.sv
package warp_seq_pkg;
  parameter int LANES     = 16;
  parameter int WARP_SIZE = 32;
  parameter int MAX_WARPS = 48;
  parameter int DATA_W    = 16;

  localparam int HALVES = WARP_SIZE / LANES;
  localparam int WID_W  = $clog2(MAX_WARPS);
  localparam int VEC_W  = LANES * DATA_W;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LO   = 2'd1,
    SQ_HI   = 2'd2
  } seqStateT;

  typedef struct packed {
    logic             fire;
    logic             upper;
    logic             last;
    logic [WID_W-1:0] warp;
  } seqStrobeT;
endpackage

// File: rtl/warp_seq_ctrl.sv
module warp_seq_ctrl
  import warp_seq_pkg::*;
(
  input  logic             aluClk,
  input  logic             rstN,
  input  logic             issueEdge,
  input  logic             instValid,
  input  logic [WID_W-1:0] instWarp,
  output logic             instReady,
  output logic             instErr,
  output seqStrobeT        strobe
);
  localparam logic [WID_W-1:0] LAST_ID = WID_W'(MAX_WARPS - 1);

  seqStateT         state;
  seqStateT         stateNext;
  logic [WID_W-1:0] curWarp;
  logic             take;
  logic             badId;
  logic             goodTake;

  // the lower-half cycle is the only one that cannot end on an accept
  assign instReady = (state != SQ_LO);
  assign take      = issueEdge & instValid & instReady;
  assign badId     = instWarp > LAST_ID;
  assign goodTake  = take & ~badId;

  always_comb begin
    case (state)
      SQ_LO:   stateNext = SQ_HI;
      default: stateNext = goodTake ? SQ_LO : SQ_IDLE;
    endcase
  end

  always_ff @(posedge aluClk or negedge rstN) begin
    if (!rstN) begin
      state   <= SQ_IDLE;
      curWarp <= '0;
      instErr <= 1'b0;
    end else begin
      state   <= stateNext;
      instErr <= take & badId;
      if (goodTake) curWarp <= instWarp;
    end
  end

  always_comb begin
    strobe.fire  = (state != SQ_IDLE);
    strobe.upper = (state == SQ_HI);
    strobe.last  = (state == SQ_HI);
    strobe.warp  = curWarp;
  end
endmodule

// File: rtl/warp_seq_lanes.sv
module warp_seq_lanes
  import warp_seq_pkg::*;
(
  input  logic             aluClk,
  input  logic             rstN,
  input  seqStrobeT        strobe,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] opC,
  output logic             resValid,
  output logic             resHalf,
  output logic [WID_W-1:0] resWarp,
  output logic [VEC_W-1:0] resData,
  output logic             doneValid,
  output logic [WID_W-1:0] doneWarp
);
  logic [VEC_W-1:0] macNext;

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      logic [DATA_W-1:0] a;
      logic [DATA_W-1:0] b;
      logic [DATA_W-1:0] c;
      assign a = opA[g*DATA_W +: DATA_W];
      assign b = opB[g*DATA_W +: DATA_W];
      assign c = opC[g*DATA_W +: DATA_W];
      assign macNext[g*DATA_W +: DATA_W] = a * b + c;
    end
  endgenerate

  always_ff @(posedge aluClk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resHalf   <= 1'b0;
      resWarp   <= '0;
      resData   <= '0;
      doneValid <= 1'b0;
      doneWarp  <= '0;
    end else begin
      resValid  <= strobe.fire;
      doneValid <= strobe.fire & strobe.last;
      if (strobe.fire) begin
        resHalf <= strobe.upper;
        resWarp <= strobe.warp;
        resData <= macNext;
      end
      if (strobe.fire & strobe.last) doneWarp <= strobe.warp;
    end
  end
endmodule

// File: rtl/warp_dual_pump_seq.sv
module warp_dual_pump_seq
  import warp_seq_pkg::*;
(
  input  logic             aluClk,
  input  logic             rstN,
  input  logic             issueEdge,
  input  logic             instValid,
  input  logic [WID_W-1:0] instWarp,
  output logic             instReady,
  output logic             instErr,
  output logic             rfRead,
  output logic [WID_W-1:0] rfWarp,
  output logic             rfHalf,
  input  logic [VEC_W-1:0] rfA,
  input  logic [VEC_W-1:0] rfB,
  input  logic [VEC_W-1:0] rfC,
  output logic             resValid,
  output logic             resHalf,
  output logic [WID_W-1:0] resWarp,
  output logic [VEC_W-1:0] resData,
  output logic             doneValid,
  output logic [WID_W-1:0] doneWarp
);
  seqStrobeT strobe;

  warp_seq_ctrl uCtrl (
    .aluClk   (aluClk),
    .rstN     (rstN),
    .issueEdge(issueEdge),
    .instValid(instValid),
    .instWarp (instWarp),
    .instReady(instReady),
    .instErr  (instErr),
    .strobe   (strobe)
  );

  assign rfRead = strobe.fire;
  assign rfWarp = strobe.warp;
  assign rfHalf = strobe.upper;

  warp_seq_lanes uLanes (
    .aluClk   (aluClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (rfA),
    .opB      (rfB),
    .opC      (rfC),
    .resValid (resValid),
    .resHalf  (resHalf),
    .resWarp  (resWarp),
    .resData  (resData),
    .doneValid(doneValid),
    .doneWarp (doneWarp)
  );
endmodule

// File: rtl/warp_seq_checker.sv
module warp_seq_checker
  import warp_seq_pkg::*;
(
  input logic             aluClk,
  input logic             rstN,
  input logic             issueEdge,
  input logic             instReady,
  input logic             instErr,
  input logic             rfRead,
  input logic [WID_W-1:0] rfWarp,
  input logic             rfHalf,
  input logic             resValid,
  input logic             resHalf,
  input logic [WID_W-1:0] resWarp,
  input logic             doneValid,
  input logic [WID_W-1:0] doneWarp
);
  AST_LOWER_NEEDS_EDGE: assert property (@(posedge aluClk) disable iff (!rstN)
    !issueEdge |=> !(rfRead && !rfHalf)); // R2

  AST_UPPER_FOLLOWS_LOWER: assert property (@(posedge aluClk) disable iff (!rstN)
    (rfRead && !rfHalf) |=> (rfRead && rfHalf && $stable(rfWarp))); // R3

  AST_RESULT_TRACKS_READ: assert property (@(posedge aluClk) disable iff (!rstN)
    rfRead |=> (resValid && resHalf == $past(rfHalf) && resWarp == $past(rfWarp))); // R4

  AST_DONE_WITH_UPPER: assert property (@(posedge aluClk) disable iff (!rstN)
    doneValid |-> (resValid && resHalf && doneWarp == resWarp)); // R5

  AST_DONE_SINGLE: assert property (@(posedge aluClk) disable iff (!rstN)
    doneValid |=> !doneValid); // R5

  AST_READY_LOW_LOWER: assert property (@(posedge aluClk) disable iff (!rstN)
    (rfRead && !rfHalf) |-> !instReady); // R6

  AST_ERR_NO_READ: assert property (@(posedge aluClk) disable iff (!rstN)
    instErr |-> !rfRead); // R7

  AST_WARP_IN_RANGE: assert property (@(posedge aluClk) disable iff (!rstN)
    rfRead |-> (rfWarp < WID_W'(MAX_WARPS))); // R7
endmodule

bind warp_dual_pump_seq warp_seq_checker uChk (
  .aluClk   (aluClk),
  .rstN     (rstN),
  .issueEdge(issueEdge),
  .instReady(instReady),
  .instErr  (instErr),
  .rfRead   (rfRead),
  .rfWarp   (rfWarp),
  .rfHalf   (rfHalf),
  .resValid (resValid),
  .resHalf  (resHalf),
  .resWarp  (resWarp),
  .doneValid(doneValid),
  .doneWarp (doneWarp)
);

// File: tb/warp_dual_pump_seq_test.sv
`timescale 1ns/1ps
module warp_dual_pump_seq_test;
  import warp_seq_pkg::*;

  logic             aluClk = 1'b0;
  logic             rstN;
  logic             issueEdge;
  logic             instValid;
  logic [WID_W-1:0] instWarp;
  logic             instReady;
  logic             instErr;
  logic             rfRead;
  logic [WID_W-1:0] rfWarp;
  logic             rfHalf;
  logic [VEC_W-1:0] rfA;
  logic [VEC_W-1:0] rfB;
  logic [VEC_W-1:0] rfC;
  logic             resValid;
  logic             resHalf;
  logic [WID_W-1:0] resWarp;
  logic [VEC_W-1:0] resData;
  logic             doneValid;
  logic [WID_W-1:0] doneWarp;

  int  checks = 0;
  int  errors = 0;
  int  salt = 1;
  bit  finished = 1'b0;
  bit  prevGood = 1'b0;
  int  prevW = 0;
  int  prevSalt = 0;

  always #4 aluClk = ~aluClk;

  warp_dual_pump_seq uut (
    .aluClk(aluClk), .rstN(rstN), .issueEdge(issueEdge), .instValid(instValid),
    .instWarp(instWarp), .instReady(instReady), .instErr(instErr),
    .rfRead(rfRead), .rfWarp(rfWarp), .rfHalf(rfHalf),
    .rfA(rfA), .rfB(rfB), .rfC(rfC),
    .resValid(resValid), .resHalf(resHalf), .resWarp(resWarp), .resData(resData),
    .doneValid(doneValid), .doneWarp(doneWarp)
  );

  function automatic logic [DATA_W-1:0] opv(input int w, input int e, input int s, input int k);
    int t;
    t = w * 37 + e * 101 + s * 13 + k * 7919;
    return DATA_W'(t ^ (t << 5) ^ (e * w * 3));
  endfunction

  function automatic logic [DATA_W-1:0] expMac(input int w, input int e, input int s);
    logic [DATA_W-1:0] a, b, c;
    a = opv(w, e, s, 0);
    b = opv(w, e, s, 1);
    c = opv(w, e, s, 2);
    return a * b + c;
  endfunction

  // external context storage model: same-cycle return
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rfA[i*DATA_W +: DATA_W] = opv(int'(rfWarp), int'(rfHalf) * LANES + i, salt, 0);
      rfB[i*DATA_W +: DATA_W] = opv(int'(rfWarp), int'(rfHalf) * LANES + i, salt, 1);
      rfC[i*DATA_W +: DATA_W] = opv(int'(rfWarp), int'(rfHalf) * LANES + i, salt, 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkHalf(input int w, input int h, input int s, input string tag);
    bit ok = 1'b1;
    int badLane = 0;
    logic [DATA_W-1:0] act = '0;
    logic [DATA_W-1:0] exp = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ok && resData[i*DATA_W +: DATA_W] !== expMac(w, h * LANES + i, s)) begin
        ok = 1'b0;
        badLane = i;
        act = resData[i*DATA_W +: DATA_W];
        exp = expMac(w, h * LANES + i, s);
      end
    end
    chk(ok, $sformatf("%s lane %0d", tag, badLane), longint'(act), longint'(exp));
  endtask

  task automatic slot(input bit v, input int w);
    bit curGood, curBad;
    @(negedge aluClk);
    chk(instReady === 1'b1, "R6 ready high at issue slot", longint'(instReady), 1);
    if (prevGood) begin
      chk(resValid === 1'b1 && resHalf === 1'b0, "R4 lower result valid", longint'({resValid, resHalf}), 2);
      chk(resWarp === WID_W'(prevW), "R4 lower result warp", longint'(resWarp), longint'(prevW));
      checkHalf(prevW, 0, prevSalt, "R4 lower lane data");
      chk(doneValid === 1'b0, "R5 no completion on lower half", longint'(doneValid), 0);
      chk(rfRead === 1'b1 && rfHalf === 1'b1 && rfWarp === WID_W'(prevW),
          "R3 upper half read", longint'({rfRead, rfHalf, rfWarp}), longint'({2'b11, WID_W'(prevW)}));
    end else begin
      chk(resValid === 1'b0 && rfRead === 1'b0, "R2 idle after empty slot", longint'({resValid, rfRead}), 0);
      if ($urandom % 4 == 0) salt++;
    end
    issueEdge = 1'b1;
    instValid = v;
    instWarp  = WID_W'(w);
    curGood = v && (w < MAX_WARPS);
    curBad  = v && (w >= MAX_WARPS);
    @(negedge aluClk);
    if (prevGood) begin
      chk(resValid === 1'b1 && resHalf === 1'b1, "R4 upper result valid", longint'({resValid, resHalf}), 3);
      checkHalf(prevW, 1, prevSalt, "R4 upper lane data");
      chk(doneValid === 1'b1 && doneWarp === WID_W'(prevW), "R5 completion with warp id",
          longint'({doneValid, doneWarp}), longint'({1'b1, WID_W'(prevW)}));
    end else begin
      chk(doneValid === 1'b0 && resValid === 1'b0, "R5 no stray completion", longint'({doneValid, resValid}), 0);
    end
    if (curGood) begin
      chk(rfRead === 1'b1 && rfHalf === 1'b0 && rfWarp === WID_W'(w), "R3 lower half read",
          longint'({rfRead, rfHalf, rfWarp}), longint'({2'b10, WID_W'(w)}));
      chk(instReady === 1'b0, "R6 ready low in lower half", longint'(instReady), 0);
    end else begin
      chk(rfRead === 1'b0 && instReady === 1'b1, "R7 no read for refused or empty slot",
          longint'({rfRead, instReady}), 1);
    end
    chk(instErr === curBad, "R7 error pulse", longint'(instErr), longint'(curBad));
    // off-edge noise must be ignored (R2)
    issueEdge = 1'b0;
    instValid = 1'($urandom % 2);
    instWarp  = WID_W'($urandom);
    prevGood = curGood;
    prevW    = w;
    prevSalt = salt;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    issueEdge = 1'b0;
    instValid = 1'b0;
    instWarp = '0;
    repeat (3) @(posedge aluClk);
    @(negedge aluClk);
    chk(instReady === 1'b1, "R1 reset ready", longint'(instReady), 1);
    chk({rfRead, resValid, doneValid, instErr} === 4'b0, "R1 reset outputs quiet",
        longint'({rfRead, resValid, doneValid, instErr}), 0);
    rstN = 1'b1;
    // directed corners
    slot(1'b1, 0);            // R8 lowest id
    slot(1'b1, 47);           // R8 highest id, back to back
    slot(1'b1, 48);           // R7 first illegal id
    slot(1'b1, 63);           // R7
    slot(1'b0, 5);
    slot(1'b1, 5);            // R8 same warp twice
    slot(1'b1, 5);
    slot(1'b0, 0);
    // constrained random
    for (int n = 0; n < 600; n++) begin
      bit v = ($urandom % 4) != 0;
      int w = ($urandom % 8 == 0) ? (MAX_WARPS + int'($urandom % 16)) : int'($urandom % MAX_WARPS);
      slot(v, w);
    end
    slot(1'b0, 0);
    slot(1'b0, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge aluClk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule